// File: doc/BRIEF.md
# PLL power and lock sequencer

This block is the control sequencer that sits between a clock-management register file and an analog PLL. It takes one-shot commands to start the PLL, stop it, or reprogram its dividers. It then drives the PLL's powerdown control, its feedback divider (NDIV), input divider (IDF) and charge-pump (CP) fields, and the select line of the downstream clock mux. That mux picks either the bypass (reference) path or the PLL output.

The order of events is fixed so that the downstream clock never sees a PLL that is unlocked or being reconfigured:

- The mux moves to bypass before the PLL is powered down.
- The mux leaves bypass only after lock has been seen through a synchroniser.
- A reprogram stops the PLL, writes the divider fields one per cycle, and then starts the PLL again.
- If lock does not arrive within a time budget given in microseconds, the block flags an error and leaves the mux on bypass.

Alongside the sequencing, the block reports the PLL output rate for software. The rate is computed from the reference frequency in kHz and the programmed dividers. It is forced to zero while the PLL is not usable.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, pdn_ctrl and byp_sel are 1, busy, done and err_tmo are 0, rate_ok is 0, rate_hz is 0, and ndiv_q/idf_q/cp_q hold their reset parameters (defaults 25, 1, 0).
- R2: An enable command (cmd_op = 1) while pdn_stat reads 0 finishes with done in the cycle after acceptance, and no output other than busy and done changes.
- R3: An enable command while pdn_stat reads 1 clears pdn_ctrl, waits for synchronised lock, and only then clears byp_sel (when HAS_BYPASS is 1); done rises in that same cycle.
- R4: If synchronised lock is not seen within TIMEOUT_US × CYC_PER_US cycles of waiting, err_tmo is set, done pulses, byp_sel stays 1 and pdn_ctrl stays 0. err_tmo clears when the next command is accepted.
- R5: A disable command (cmd_op = 2) while pdn_stat reads 1 finishes with done in the cycle after acceptance and changes nothing.
- R6: A disable command while pdn_stat reads 0 sets byp_sel to 1, and pdn_ctrl goes to 1 in the following cycle.
- R7: A reprogram command (cmd_op = 3) runs a full disable, then writes ndiv_q, idf_q and cp_q from the values captured at acceptance, in three consecutive cycles in that order, then runs a full enable. The divider fields change only while pdn_ctrl is 1.
- R8: A command presented while busy is 1 is ignored and has no later effect.
- R9: done is high for exactly one cycle at the end of every sequence.
- R10: rate_hz equals ((2 × ref_khz × ndiv_q) / idf_q) × 1000, using integer division, and rate_ok is 1 when pdn_stat is 0, synchronised lock is 1 and idf_q is nonzero. Otherwise both are 0. The value registers one cycle after its inputs.
- R11: lock_raw passes through a two-flop synchroniser, so byp_sel falls three clock edges after lock_raw rises in the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 none, 1 enable, 2 disable, 3 reprogram |
| cmd_ndiv | input | NDIV_W | New feedback divider for reprogram |
| cmd_idf | input | IDF_W | New input divider for reprogram |
| cmd_cp | input | CP_W | New charge-pump setting for reprogram |
| ref_khz | input | KHZ_W | Reference frequency in kHz |
| pdn_stat | input | 1 | PLL reports powered down (1) or up (0) |
| lock_raw | input | 1 | Asynchronous lock indication from the PLL |
| pdn_ctrl | output | 1 | Powerdown request to the PLL (1 = off) |
| ndiv_q | output | NDIV_W | Feedback divider field |
| idf_q | output | IDF_W | Input divider field |
| cp_q | output | CP_W | Charge-pump field |
| byp_sel | output | 1 | Clock mux select, 1 = bypass path |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_tmo | output | 1 | Lock wait expired |
| rate_ok | output | 1 | rate_hz is meaningful |
| rate_hz | output | RATE_W | Computed PLL output rate in Hz |

## Verification
Two events can fall in the same cycle. The first is the end of a lock wait, where bypass release and the done pulse land on one edge. The second is a new command arriving while a sequence is still in flight. The bench holds back lock during an enable, presents a disable command in the middle of the wait, and then lets lock through. It counts the edges from the rise of lock_raw to the fall of byp_sel and requires exactly three. It then requires that pdn_ctrl and byp_sel still show a running PLL and that no second done pulse follows, which proves the disable left no trace.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_CHK,
    S_EN_WAIT,
    S_DIS_CHK,
    S_DIS_PDN,
    S_WR_NDIV,
    S_WR_IDF,
    S_WR_CP,
    S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_ENABLE  = 2'd1,
    OP_DISABLE = 2'd2,
    OP_REPROG  = 2'd3
  } seq_op_t;

  // Output rate in Hz: reference scaled to kHz first so the product stays small.
  function automatic logic [63:0] pll_rate_hz(input logic [63:0] khz,
                                              input logic [63:0] ndiv,
                                              input logic [63:0] idf);
    logic [63:0] vco_khz;
    if (idf == 64'd0) return 64'd0;
    vco_khz = (64'd2 * khz * ndiv) / idf;
    return vco_khz * 64'd1000;
  endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(LIMIT - 1));
  assign hit    = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (run && !at_end)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // Count never runs past the last waiting cycle (R4)
  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_end) |=> (clr || cnt_q == CNT_W'(LIMIT - 1)));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_seq_pkg::*;
#(
  parameter int KHZ_W  = 20,
  parameter int NDIV_W = 8,
  parameter int IDF_W  = 3,
  parameter int RATE_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              powered,
  input  logic              locked,
  input  logic [KHZ_W-1:0]  ref_khz,
  input  logic [NDIV_W-1:0] ndiv,
  input  logic [IDF_W-1:0]  idf,
  output logic              rate_ok,
  output logic [RATE_W-1:0] rate_hz
);
  logic        usable;
  logic [63:0] full_rate;

  assign usable    = powered && locked && (idf != '0);
  assign full_rate = pll_rate_hz(64'(ref_khz), 64'(ndiv), 64'(idf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_ok <= 1'b0;
      rate_hz <= '0;
    end else begin
      rate_ok <= usable;
      rate_hz <= usable ? full_rate[RATE_W-1:0] : '0;
    end
  end

  // An unpowered PLL reports zero on the next cycle (R10)
  assert_rate_zero_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |=> (rate_hz == '0 && !rate_ok));
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int          NDIV_W     = 8,
  parameter int          IDF_W      = 3,
  parameter int          CP_W       = 5,
  parameter int          KHZ_W      = 20,
  parameter int          RATE_W     = 48,
  parameter int          CYC_PER_US = 125,
  parameter int          TIMEOUT_US = 10000,
  parameter int          SYNC_STAGES = 2,
  parameter bit          HAS_BYPASS = 1'b1,
  parameter logic [7:0]  NDIV_RST   = 8'd25,
  parameter logic [2:0]  IDF_RST    = 3'd1,
  parameter logic [4:0]  CP_RST     = 5'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [NDIV_W-1:0] cmd_ndiv,
  input  logic [IDF_W-1:0]  cmd_idf,
  input  logic [CP_W-1:0]   cmd_cp,
  input  logic [KHZ_W-1:0]  ref_khz,
  input  logic              pdn_stat,
  input  logic              lock_raw,
  output logic              pdn_ctrl,
  output logic [NDIV_W-1:0] ndiv_q,
  output logic [IDF_W-1:0]  idf_q,
  output logic [CP_W-1:0]   cp_q,
  output logic              byp_sel,
  output logic              busy,
  output logic              done,
  output logic              err_tmo,
  output logic              rate_ok,
  output logic [RATE_W-1:0] rate_hz
);
  localparam int   LIMIT   = TIMEOUT_US * CYC_PER_US;
  localparam logic BYP_RST = HAS_BYPASS ? 1'b1 : 1'b0;

  seq_state_t        state_q;
  logic              reprog_q;
  logic [NDIV_W-1:0] ndiv_stage_q;
  logic [IDF_W-1:0]  idf_stage_q;
  logic [CP_W-1:0]   cp_stage_q;

  // Named internal events
  logic    lock_seen;
  logic    tmo_hit;
  logic    timer_clr;
  logic    timer_run;
  logic    cmd_accept;
  seq_op_t op_in;

  assign op_in      = seq_op_t'(cmd_op);
  assign cmd_accept = (state_q == S_IDLE) && cmd_valid && (op_in != OP_NONE);
  assign timer_clr  = (state_q == S_EN_CHK);
  assign timer_run  = (state_q == S_EN_WAIT);
  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_DONE);

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lock_raw),
    .dout (lock_seen)
  );

  pll_lock_timer #(.LIMIT(LIMIT)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (timer_clr),
    .run  (timer_run),
    .hit  (tmo_hit)
  );

  pll_rate_calc #(
    .KHZ_W (KHZ_W),
    .NDIV_W(NDIV_W),
    .IDF_W (IDF_W),
    .RATE_W(RATE_W)
  ) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .powered(!pdn_stat),
    .locked (lock_seen),
    .ref_khz(ref_khz),
    .ndiv   (ndiv_q),
    .idf    (idf_q),
    .rate_ok(rate_ok),
    .rate_hz(rate_hz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      reprog_q     <= 1'b0;
      pdn_ctrl     <= 1'b1;
      byp_sel      <= BYP_RST;
      err_tmo      <= 1'b0;
      ndiv_q       <= NDIV_W'(NDIV_RST);
      idf_q        <= IDF_W'(IDF_RST);
      cp_q         <= CP_W'(CP_RST);
      ndiv_stage_q <= '0;
      idf_stage_q  <= '0;
      cp_stage_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (cmd_accept) begin
            err_tmo <= 1'b0;
            case (op_in)
              OP_ENABLE: begin
                reprog_q <= 1'b0;
                state_q  <= S_EN_CHK;
              end
              OP_DISABLE: begin
                reprog_q <= 1'b0;
                state_q  <= S_DIS_CHK;
              end
              default: begin
                reprog_q     <= 1'b1;
                ndiv_stage_q <= cmd_ndiv;
                idf_stage_q  <= cmd_idf;
                cp_stage_q   <= cmd_cp;
                state_q      <= S_DIS_CHK;
              end
            endcase
          end
        end
        S_DIS_CHK: begin
          if (pdn_stat) begin
            state_q <= reprog_q ? S_WR_NDIV : S_DONE;
          end else begin
            if (HAS_BYPASS) byp_sel <= 1'b1;
            state_q <= S_DIS_PDN;
          end
        end
        S_DIS_PDN: begin
          pdn_ctrl <= 1'b1;
          state_q  <= reprog_q ? S_WR_NDIV : S_DONE;
        end
        S_WR_NDIV: begin
          ndiv_q  <= ndiv_stage_q;
          state_q <= S_WR_IDF;
        end
        S_WR_IDF: begin
          idf_q   <= idf_stage_q;
          state_q <= S_WR_CP;
        end
        S_WR_CP: begin
          cp_q    <= cp_stage_q;
          state_q <= S_EN_CHK;
        end
        S_EN_CHK: begin
          if (!pdn_stat) begin
            state_q <= S_DONE;
          end else begin
            pdn_ctrl <= 1'b0;
            state_q  <= S_EN_WAIT;
          end
        end
        S_EN_WAIT: begin
          if (lock_seen) begin
            if (HAS_BYPASS) byp_sel <= 1'b0;
            state_q <= S_DONE;
          end else if (tmo_hit) begin
            err_tmo <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_DONE: begin
          reprog_q <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Bypass is already selected when the PLL is told to power down (R6)
  assert_byp_before_pdn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BYPASS && $rose(pdn_ctrl)) |-> $past(byp_sel));

  // Bypass is released only on synchronised lock of a running PLL (R3)
  assert_byp_release_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byp_sel) |-> ($past(lock_seen) && !pdn_ctrl));

  // Divider fields only move while the PLL is held off (R7)
  assert_div_write_powered_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ndiv_q) || !$stable(idf_q) || !$stable(cp_q)) |-> pdn_ctrl);

  // A lock timeout leaves the clock on bypass (R4)
  assert_tmo_keeps_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_BYPASS && $rose(err_tmo)) |-> (byp_sel && !pdn_ctrl));

  // done lasts one cycle (R9)
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // A command during a sequence does not restart it (R8)
  assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(done)) |-> (state_q != S_EN_CHK || $past(state_q) == S_WR_CP));
endmodule

// File: tb/pll_seq_top_tb_top.sv
module pll_seq_top_tb_top;
  localparam int CPU      = 4;
  localparam int TUS      = 10;
  localparam int LIMIT    = CPU * TUS;
  localparam int LOCK_DLY = 6;

  typedef struct packed {
    logic [19:0] khz;
    logic [7:0]  nd;
    logic [2:0]  id;
    logic [4:0]  cp;
    logic [47:0] rate;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{20'd30000, 8'd40,  3'd2, 5'd10, 48'd1200000000},
    '{20'd30000, 8'd50,  3'd3, 5'd7,  48'd1000000000},
    '{20'd25000, 8'd255, 3'd7, 5'd25, 48'd1821428000},
    '{20'd27000, 8'd8,   3'd2, 5'd6,  48'd216000000},
    '{20'd24576, 8'd100, 3'd5, 5'd12, 48'd983040000},
    '{20'd30000, 8'd40,  3'd0, 5'd9,  48'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_ndiv = 8'd0;
  logic [2:0]  cmd_idf = 3'd0;
  logic [4:0]  cmd_cp = 5'd0;
  logic [19:0] ref_khz = 20'd30000;
  logic        pdn_stat;
  logic        lock_raw;
  logic        pdn_ctrl, byp_sel, busy, done, err_tmo, rate_ok;
  logic [7:0]  ndiv_q;
  logic [2:0]  idf_q;
  logic [4:0]  cp_q;
  logic [47:0] rate_hz;

  int n_chk = 0;
  int n_fail = 0;
  int t_byp_rise, t_byp_fall, t_pdn_rise, t_nd, t_id, t_cp, t_done;
  logic lock_allow = 1'b1;
  int   lock_cnt;

  always #4 clk = ~clk;

  pll_seq_top #(.CYC_PER_US(CPU), .TIMEOUT_US(TUS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ndiv(cmd_ndiv), .cmd_idf(cmd_idf), .cmd_cp(cmd_cp), .ref_khz(ref_khz),
    .pdn_stat(pdn_stat), .lock_raw(lock_raw), .pdn_ctrl(pdn_ctrl),
    .ndiv_q(ndiv_q), .idf_q(idf_q), .cp_q(cp_q), .byp_sel(byp_sel),
    .busy(busy), .done(done), .err_tmo(err_tmo), .rate_ok(rate_ok),
    .rate_hz(rate_hz)
  );

  // Simple PLL model: status follows control one cycle later, lock after a delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_stat <= 1'b1;
      lock_cnt <= 0;
    end else begin
      pdn_stat <= pdn_ctrl;
      if (pdn_stat)                lock_cnt <= 0;
      else if (lock_cnt < LOCK_DLY) lock_cnt <= lock_cnt + 1;
    end
  end
  assign lock_raw = !pdn_stat && (lock_cnt >= LOCK_DLY) && lock_allow;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] nd, input logic [2:0] id,
                       input logic [4:0] cp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ndiv = nd; cmd_idf = id; cmd_cp = cp;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  // Walks negedges until done, noting the cycle of every output change
  task automatic wait_done();
    logic pb, pp;
    logic [7:0] pn; logic [2:0] pi; logic [4:0] pc;
    pb = byp_sel; pp = pdn_ctrl; pn = ndiv_q; pi = idf_q; pc = cp_q;
    t_byp_rise = -1; t_byp_fall = -1; t_pdn_rise = -1; t_nd = -1; t_id = -1; t_cp = -1;
    t_done = -1;
    for (int c = 1; c <= 500; c++) begin
      @(negedge clk);
      if (byp_sel && !pb)  t_byp_rise = c;
      if (!byp_sel && pb)  t_byp_fall = c;
      if (pdn_ctrl && !pp) t_pdn_rise = c;
      if (ndiv_q != pn)    t_nd = c;
      if (idf_q != pi)     t_id = c;
      if (cp_q != pc)      t_cp = c;
      pb = byp_sel; pp = pdn_ctrl; pn = ndiv_q; pi = idf_q; pc = cp_q;
      if (done) begin
        t_done = c;
        break;
      end
    end
    if (t_done < 0) chk("R9", "done never seen", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("WDOG", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "pdn_ctrl", pdn_ctrl, 1);
    chk("R1", "byp_sel", byp_sel, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err_tmo", err_tmo, 0);
    chk("R1", "ndiv_q", ndiv_q, 25);
    chk("R1", "idf_q", idf_q, 1);
    chk("R1", "cp_q", cp_q, 0);
    chk("R1", "rate_hz", rate_hz, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rate_ok after release", rate_ok, 0);

    // R3 enable from powered down
    issue(2'd1, 8'd0, 3'd0, 5'd0);
    wait_done();
    chk("R3", "pdn_ctrl", pdn_ctrl, 0);
    chk("R3", "byp_sel", byp_sel, 0);
    chk("R3", "byp falls with done", t_byp_fall, t_done);
    chk("R3", "err_tmo", err_tmo, 0);
    repeat (2) @(negedge clk);
    chk("R10", "rate with reset dividers", rate_hz, 48'd1500000000);
    chk("R10", "rate_ok", rate_ok, 1);

    // R2 enable when already running, R9 single done
    issue(2'd1, 8'd0, 3'd0, 5'd0);
    wait_done();
    chk("R2", "latency", t_done, 1);
    chk("R2", "no byp change", t_byp_rise, -1);
    chk("R2", "pdn_ctrl", pdn_ctrl, 0);
    @(negedge clk);
    chk("R9", "done low after pulse", done, 0);
    chk("R9", "busy low after pulse", busy, 0);

    // R7 / R10 table of reprograms
    foreach (VECS[k]) begin
      ref_khz = VECS[k].khz;
      issue(2'd3, VECS[k].nd, VECS[k].id, VECS[k].cp);
      wait_done();
      chk("R7", "ndiv after power-down", (t_nd > t_pdn_rise && t_pdn_rise > 0) ? 1 : 0, 1);
      chk("R7", "idf follows ndiv", t_id - t_nd, 1);
      chk("R7", "cp follows idf", t_cp - t_id, 1);
      chk("R7", "bypass released after writes", (t_byp_fall > t_cp) ? 1 : 0, 1);
      chk("R7", "ndiv value", ndiv_q, VECS[k].nd);
      chk("R7", "idf value", idf_q, VECS[k].id);
      chk("R7", "cp value", cp_q, VECS[k].cp);
      chk("R6", "byp before pdn in reprogram", t_pdn_rise - t_byp_rise, 1);
      repeat (3) @(negedge clk);
      chk("R10", "rate vector", rate_hz, VECS[k].rate);
      chk("R10", "rate_ok vector", rate_ok, (VECS[k].id != 0) ? 1 : 0);
    end

    // R6 disable when running
    issue(2'd2, 8'd0, 3'd0, 5'd0);
    wait_done();
    chk("R6", "pdn one cycle after byp", t_pdn_rise - t_byp_rise, 1);
    chk("R6", "pdn_ctrl", pdn_ctrl, 1);
    chk("R6", "byp_sel", byp_sel, 1);
    repeat (4) @(negedge clk);
    chk("R10", "rate zero when off", rate_hz, 0);
    chk("R10", "rate_ok zero when off", rate_ok, 0);

    // R5 disable when already off
    issue(2'd2, 8'd0, 3'd0, 5'd0);
    wait_done();
    chk("R5", "latency", t_done, 1);
    chk("R5", "no pdn change", t_pdn_rise, -1);
    chk("R5", "byp_sel", byp_sel, 1);

    // R11 synchroniser depth, R8 command ignored while busy
    lock_allow = 1'b0;
    issue(2'd1, 8'd0, 3'd0, 5'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    repeat (15) @(negedge clk);
    lock_allow = 1'b1;
    lat = 0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (!byp_sel) begin
        lat = c;
        break;
      end
    end
    chk("R11", "edges from lock to bypass release", lat, 3);
    chk("R3", "done with release", done, 1);
    repeat (3) @(negedge clk);
    chk("R8", "pdn_ctrl after ignored disable", pdn_ctrl, 0);
    chk("R8", "byp_sel after ignored disable", byp_sel, 0);
    chk("R8", "no second done", done, 0);
    chk("R8", "idle", busy, 0);

    // R4 lock timeout
    issue(2'd2, 8'd0, 3'd0, 5'd0);
    wait_done();
    repeat (2) @(negedge clk);
    lock_allow = 1'b0;
    issue(2'd1, 8'd0, 3'd0, 5'd0);
    wait_done();
    chk("R4", "err_tmo", err_tmo, 1);
    chk("R4", "byp_sel held", byp_sel, 1);
    chk("R4", "pdn_ctrl still 0", pdn_ctrl, 0);
    chk("R4", "wait length in range", (t_done >= LIMIT && t_done <= LIMIT + 2) ? 1 : 0, 1);
    lock_allow = 1'b1;
    issue(2'd2, 8'd0, 3'd0, 5'd0);
    chk("R4", "err cleared on accept", err_tmo, 0);
    wait_done();
    chk("R6", "disable after timeout", pdn_ctrl, 1);

    report();
  end
endmodule